// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general-purpose register store of a processor core that has seven operating modes. Software addresses it with a 4-bit architectural index (0 to 15). The block turns that index into one of 31 physical 32-bit registers, using the 5-bit mode field that the core supplies. A fast-interrupt mode has private copies of the upper seven indices below the program counter. Four other privileged modes each keep private copies of only the stack and link indices. The unprivileged mode and the system mode share one unbanked set.

There are two combinational read ports and one write port. The write port updates the selected register on the rising clock edge. Privileged code can reach the unbanked copies through a user-bank input, which makes every port decode its index as if the mode were the unprivileged one. A mode value outside the seven legal encodings is reported on a flag output, and every write is blocked while that flag is high. The core uses the flag to force a reset.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every physical register reads zero, whatever the mode.
- R2: Index 15 (the program counter) is one register shared by all modes. A write to it in any mode is visible at index 15 in every other mode.
- R3: In fast-interrupt mode (mode 5'b10001), indices 8 to 14 reach seven private registers, and indices 0 to 7 reach the unbanked set. Writing one of indices 8 to 14 in this mode leaves the unbanked copy of that index unchanged.
- R4: The modes 5'b10010, 5'b10011, 5'b10111 and 5'b11011 each own private copies of indices 13 and 14, the link register included, and of those indices only. Indices 0 to 12 in these modes reach the unbanked set.
- R5: Modes 5'b10000 and 5'b11111 address the same unbanked registers for every index.
- R6: Both read ports are combinational. A read of the register being written in the same cycle returns the old value, and the new value appears after the clock edge.
- R7: `illegal_mode_o` is high, combinationally, exactly when `mode_i` is not one of the seven encodings listed in R3 to R5.
- R8: While `illegal_mode_o` is high, no register changes, and reads use the unbanked mapping.
- R9: When `user_bank_i` is high, the read and write ports decode their indices as in mode 5'b10000, regardless of `mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current processor mode field |
| user_bank_i | input | 1 | Forces unbanked decoding on all ports |
| rd_a_idx_i | input | 4 | Read port A architectural index |
| rd_a_data_o | output | DATA_W | Read port A data |
| rd_b_idx_i | input | 4 | Read port B architectural index |
| rd_b_data_o | output | DATA_W | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write architectural index |
| wr_data_i | input | DATA_W | Write data |
| illegal_mode_o | output | 1 | Mode field is not a legal encoding |

## Verification
The hardest case to reach is a banked register that diverges from its unbanked copy while a different mode, or the user-bank input, reads the same index. Every mode must hold a distinct value in the same slot before a cross-mode read can tell a wrong mapping apart from a right one. Directed phases therefore write a distinct value to each bank in turn and then read all of them back from other modes. After that, a long pseudo-random phase mixes legal modes, illegal mode values, user-bank accesses and same-index read/write collisions. Every cycle of that phase is checked against a behavioural model that keeps separate storage for each mode.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

   localparam int unsigned IDX_W      = 4;
   localparam int unsigned NUM_IDX    = 1 << IDX_W;
   localparam int unsigned PC_IDX     = NUM_IDX - 1;
   localparam int unsigned FIQ_LO     = 8;
   localparam int unsigned FIQ_HI     = 14;
   localparam int unsigned SHORT_LO   = 13;
   localparam int unsigned SHORT_HI   = 14;
   localparam int unsigned FIQ_CNT    = FIQ_HI - FIQ_LO + 1;
   localparam int unsigned SHORT_CNT  = SHORT_HI - SHORT_LO + 1;
   localparam int unsigned SHORT_BNKS = 4;
   localparam int unsigned FIQ_BASE   = NUM_IDX;
   localparam int unsigned SHORT_BASE = FIQ_BASE + FIQ_CNT;
   localparam int unsigned NPHYS      = SHORT_BASE + SHORT_BNKS * SHORT_CNT;
   localparam int unsigned PHYS_W     = $clog2(NPHYS);

   localparam logic [4:0] MODE_USR = 5'b10000;
   localparam logic [4:0] MODE_FIQ = 5'b10001;
   localparam logic [4:0] MODE_IRQ = 5'b10010;
   localparam logic [4:0] MODE_SVC = 5'b10011;
   localparam logic [4:0] MODE_ABT = 5'b10111;
   localparam logic [4:0] MODE_UND = 5'b11011;
   localparam logic [4:0] MODE_SYS = 5'b11111;

   typedef enum logic [2:0] {
      BANK_NONE  = 3'd0,
      BANK_FAST  = 3'd1,
      BANK_IRQ   = 3'd2,
      BANK_SVC   = 3'd3,
      BANK_ABT   = 3'd4,
      BANK_UND   = 3'd5
   } bank_e;

endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
   import banked_regfile_pkg::*;
(
   input  logic [4:0] mode_i,
   output bank_e      bank_o,
   output logic       illegal_o
);

   always_comb begin
      bank_o    = BANK_NONE;
      illegal_o = 1'b0;
      unique case (mode_i)
         MODE_USR, MODE_SYS: bank_o = BANK_NONE;
         MODE_FIQ:           bank_o = BANK_FAST;
         MODE_IRQ:           bank_o = BANK_IRQ;
         MODE_SVC:           bank_o = BANK_SVC;
         MODE_ABT:           bank_o = BANK_ABT;
         MODE_UND:           bank_o = BANK_UND;
         default:            illegal_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/rf_index_map.sv
module rf_index_map
   import banked_regfile_pkg::*;
(
   input  bank_e              bank_i,
   input  logic [IDX_W-1:0]   idx_i,
   output logic [PHYS_W-1:0]  phys_o
);

   localparam int unsigned SEL_W = $clog2(SHORT_BNKS);

   logic                in_fast;
   logic                in_short;
   logic                short_bank;
   logic [SEL_W-1:0]    short_sel;

   assign in_fast    = (int'(idx_i) >= FIQ_LO) && (int'(idx_i) <= FIQ_HI);
   assign in_short   = (int'(idx_i) >= SHORT_LO) && (int'(idx_i) <= SHORT_HI);
   assign short_bank = (bank_i != BANK_NONE) && (bank_i != BANK_FAST);
   assign short_sel  = SEL_W'(int'(bank_i) - int'(BANK_IRQ));

   always_comb begin
      phys_o = PHYS_W'(idx_i);
      if (bank_i == BANK_FAST && in_fast) begin
         phys_o = PHYS_W'(FIQ_BASE + int'(idx_i) - FIQ_LO);
      end else if (short_bank && in_short) begin
         phys_o = PHYS_W'(SHORT_BASE + int'(short_sel) * SHORT_CNT
                          + int'(idx_i) - SHORT_LO);
      end
   end

endmodule

// File: rtl/rf_storage.sv
module rf_storage
   import banked_regfile_pkg::*;
#(
   parameter int unsigned DATA_W = 32
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPHYS-1:0]              wr_sel_i,
   input  logic [DATA_W-1:0]             wr_data_i,
   output logic [NPHYS-1:0][DATA_W-1:0]  q_o
);

   for (genvar p = 0; p < NPHYS; p++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_sel_i[p]) begin
            q <= wr_data_i;
         end
      end
      assign q_o[p] = q;
   end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import banked_regfile_pkg::*;
#(
   parameter int unsigned DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        mode_i,
   input  logic              user_bank_i,
   input  logic [3:0]        rd_a_idx_i,
   output logic [DATA_W-1:0] rd_a_data_o,
   input  logic [3:0]        rd_b_idx_i,
   output logic [DATA_W-1:0] rd_b_data_o,
   input  logic              wr_en_i,
   input  logic [3:0]        wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              illegal_mode_o
);

   initial begin
      if (DATA_W < 8 || DATA_W > 128) begin
         $error("banked_regfile: DATA_W %0d out of range", DATA_W);
      end
      if (NPHYS != 31) begin
         $error("banked_regfile: physical count %0d unexpected", NPHYS);
      end
   end

   bank_e                         mode_bank;
   bank_e                         eff_bank;
   logic                          illegal;
   logic [PHYS_W-1:0]             rd_a_phys;
   logic [PHYS_W-1:0]             rd_b_phys;
   logic [PHYS_W-1:0]             wr_phys;
   logic [NPHYS-1:0]              wr_sel;
   logic [NPHYS-1:0][DATA_W-1:0]  phys_q;

   rf_mode_decode u_dec (
      .mode_i    (mode_i),
      .bank_o    (mode_bank),
      .illegal_o (illegal)
   );

   assign eff_bank = (user_bank_i || illegal) ? BANK_NONE : mode_bank;

   rf_index_map u_map_a (.bank_i(eff_bank), .idx_i(rd_a_idx_i), .phys_o(rd_a_phys));
   rf_index_map u_map_b (.bank_i(eff_bank), .idx_i(rd_b_idx_i), .phys_o(rd_b_phys));
   rf_index_map u_map_w (.bank_i(eff_bank), .idx_i(wr_idx_i),   .phys_o(wr_phys));

   always_comb begin
      wr_sel = '0;
      if (wr_en_i && !illegal) begin
         wr_sel[wr_phys] = 1'b1;
      end
   end

   rf_storage #(.DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data_i),
      .q_o       (phys_q)
   );

   assign rd_a_data_o    = phys_q[rd_a_phys];
   assign rd_b_data_o    = phys_q[rd_b_phys];
   assign illegal_mode_o = illegal;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
   import banked_regfile_pkg::*;
#(
   parameter int unsigned DATA_W = 32
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [4:0]                    mode_i,
   input  logic                          user_bank_i,
   input  logic [3:0]                    rd_a_idx_i,
   input  logic [DATA_W-1:0]             wr_data_i,
   input  logic                          illegal_mode_o,
   input  logic [PHYS_W-1:0]             rd_a_phys,
   input  logic [PHYS_W-1:0]             rd_b_phys,
   input  logic [NPHYS-1:0]              wr_sel,
   input  logic [NPHYS-1:0][DATA_W-1:0]  phys_q
);

   assert_wr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));

   assert_no_write_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_mode_o |-> (wr_sel == '0));

   assert_user_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
      user_bank_i |-> (int'(rd_a_phys) < NUM_IDX && int'(rd_b_phys) < NUM_IDX));

   assert_pc_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx_i == 4'd15) |-> (int'(rd_a_phys) == PC_IDX));

   assert_fast_private_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_FIQ && !user_bank_i && rd_a_idx_i >= 4'd8 && rd_a_idx_i <= 4'd14)
      |-> (int'(rd_a_phys) >= FIQ_BASE && int'(rd_a_phys) < SHORT_BASE));

   for (genvar p = 0; p < NPHYS; p++) begin : g_reg_chk
      assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
         wr_sel[p] |=> (phys_q[p] == $past(wr_data_i)));
      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_sel[p] |=> $stable(phys_q[p]));
   end

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode_i         (mode_i),
   .user_bank_i    (user_bank_i),
   .rd_a_idx_i     (rd_a_idx_i),
   .wr_data_i      (wr_data_i),
   .illegal_mode_o (illegal_mode_o),
   .rd_a_phys      (rd_a_phys),
   .rd_b_phys      (rd_b_phys),
   .wr_sel         (wr_sel),
   .phys_q         (phys_q)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    mode = 5'b10000;
   logic          ub = 1'b0;
   logic [3:0]    ra = '0, rb = '0, wi = '0;
   logic          we = 1'b0;
   logic [DW-1:0] wd = '0;
   logic [DW-1:0] rda, rdb;
   logic          ill;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   banked_regfile #(.DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .user_bank_i(ub),
      .rd_a_idx_i(ra), .rd_a_data_o(rda), .rd_b_idx_i(rb), .rd_b_data_o(rdb),
      .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd), .illegal_mode_o(ill)
   );

   // Behavioural model: a shared set plus separate per-mode private stores.
   logic [DW-1:0] m_usr [16];
   logic [DW-1:0] m_fast [8:14];
   logic [DW-1:0] m_priv [4][13:14];

   function automatic bit legal(input logic [4:0] m);
      return m inside {5'b10000, 5'b10001, 5'b10010, 5'b10011,
                       5'b10111, 5'b11011, 5'b11111};
   endfunction

   function automatic int priv_slot(input logic [4:0] m);
      case (m)
         5'b10010: return 0;
         5'b10011: return 1;
         5'b10111: return 2;
         5'b11011: return 3;
         default:  return -1;
      endcase
   endfunction

   function automatic logic [DW-1:0] m_read(input logic [4:0] m, input bit u, input int i);
      if (!u && legal(m)) begin
         if (m == 5'b10001 && i >= 8 && i <= 14) return m_fast[i];
         if (priv_slot(m) >= 0 && (i == 13 || i == 14)) return m_priv[priv_slot(m)][i];
      end
      return m_usr[i];
   endfunction

   task automatic m_write(input logic [4:0] m, input bit u, input int i, input logic [DW-1:0] d);
      if (!legal(m)) return;
      if (!u && m == 5'b10001 && i >= 8 && i <= 14) m_fast[i] = d;
      else if (!u && priv_slot(m) >= 0 && (i == 13 || i == 14)) m_priv[priv_slot(m)][i] = d;
      else m_usr[i] = d;
   endtask

   task automatic check(input string tag, input string what, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag, input logic [4:0] m, input bit u,
                       input int a, input int b, input bit w, input int wix,
                       input logic [DW-1:0] d);
      @(negedge clk);
      mode = m; ub = u; ra = 4'(a); rb = 4'(b); we = w; wi = 4'(wix); wd = d;
      #1;
      check(tag, "port A", rda, m_read(m, u, a));
      check(tag, "port B", rdb, m_read(m, u, b));
      check(tag, "illegal flag", DW'(ill), DW'(!legal(m)));
      @(posedge clk);
      if (w) m_write(m, u, wix, d);
   endtask

   task automatic rd(input string tag, input logic [4:0] m, input bit u, input int a);
      step(tag, m, u, a, 15 - a, 1'b0, 0, '0);
   endtask

   task automatic wr(input string tag, input logic [4:0] m, input bit u, input int i,
                     input logic [DW-1:0] d);
      step(tag, m, u, i, i, 1'b1, i, d);
   endtask

   localparam logic [4:0] LM [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                     5'b10111, 5'b11011, 5'b11111};

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < 16; i++) m_usr[i] = '0;
      for (int i = 8; i <= 14; i++) m_fast[i] = '0;
      for (int k = 0; k < 4; k++) begin m_priv[k][13] = '0; m_priv[k][14] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state in every legal mode
      for (int k = 0; k < 7; k++)
         for (int i = 0; i < 16; i++) rd("R1", LM[k], 1'b0, i);

      // R5: unbanked set written in one mode, read in the other
      for (int i = 0; i < 16; i++) wr("R5", 5'b10000, 1'b0, i, 32'h1000_0000 + i);
      for (int i = 0; i < 16; i++) rd("R5", 5'b11111, 1'b0, i);
      wr("R5", 5'b11111, 1'b0, 4, 32'h5555_0004);
      rd("R5", 5'b10000, 1'b0, 4);

      // R3: fast-interrupt private copies of 8..14
      for (int i = 0; i < 16; i++) wr("R3", 5'b10001, 1'b0, i, 32'hF1F0_0000 + i);
      for (int i = 0; i < 16; i++) rd("R3", 5'b10000, 1'b0, i);
      for (int i = 0; i < 16; i++) rd("R3", 5'b10001, 1'b0, i);

      // R4: each short-banked mode owns only 13 and 14 (link register included)
      for (int k = 2; k < 6; k++) begin
         wr("R4", LM[k], 1'b0, 14, 32'hC0DE_0000 + k);
         wr("R4", LM[k], 1'b0, 13, 32'h5EED_0000 + k);
         wr("R4", LM[k], 1'b0, 12, 32'h0C00_0000 + k);
      end
      for (int k = 0; k < 7; k++)
         for (int i = 11; i < 16; i++) rd("R4", LM[k], 1'b0, i);

      // R2: program counter shared across modes
      wr("R2", 5'b11011, 1'b0, 15, 32'hBEEF_0015);
      for (int k = 0; k < 7; k++) rd("R2", LM[k], 1'b0, 15);

      // R6: read and write of the same register in one cycle
      step("R6", 5'b10010, 1'b0, 14, 14, 1'b1, 14, 32'hAAAA_5555);
      rd("R6", 5'b10010, 1'b0, 14);
      step("R6", 5'b10000, 1'b0, 3, 3, 1'b1, 3, 32'h0303_0303);
      rd("R6", 5'b10000, 1'b0, 3);

      // R7 / R8: illegal modes flag and block writes
      for (int v = 0; v < 32; v++) begin
         step("R7", 5'(v), 1'b0, 13, 9, 1'b1, v % 16, 32'hDEAD_0000 + v);
      end
      for (int i = 0; i < 16; i++) rd("R8", 5'b10000, 1'b0, i);
      for (int i = 8; i <= 14; i++) rd("R8", 5'b10001, 1'b0, i);

      // R9: user-bank access from privileged modes
      wr("R9", 5'b10001, 1'b1, 10, 32'h0000_A010);
      wr("R9", 5'b10011, 1'b1, 14, 32'h0000_A014);
      rd("R9", 5'b10000, 1'b0, 10);
      rd("R9", 5'b10000, 1'b0, 14);
      rd("R9", 5'b10001, 1'b0, 10);
      rd("R9", 5'b10011, 1'b0, 14);
      rd("R9", 5'b10001, 1'b1, 10);

      // Mixed pseudo-random traffic against the model (R3 R4 R6 R8 R9)
      for (int n = 0; n < 4000; n++) begin
         logic [4:0] m;
         int sel = $urandom_range(0, 9);
         m = (sel < 7) ? LM[sel] : 5'($urandom);
         step("R4", m, ($urandom_range(0, 5) == 0), $urandom_range(0, 15),
              $urandom_range(0, 15), ($urandom_range(0, 2) != 0),
              $urandom_range(0, 15), $urandom);
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule